// File: doc/BRIEF.md
# Chainable Unsigned Magnitude Comparator

This block compares two unsigned operands and reports whether the first is greater than, less than or equal to the second. It is built from identical four-bit slices. Each slice has three verdict inputs that carry the result of the slice below it, and three verdict outputs. Each slice looks only at its own bits until it finds that they all match. In that case it passes the incoming verdict through. When its bits differ, the most significant differing bit decides the result.

The top level joins a parameterised number of slices into one wide comparator. By default it joins two slices into an 8-bit comparator. The verdict inputs of the lowest slice are exposed as ports. Tied to "equal", they make the top a plain comparator. Fed from another comparator, they extend the word further. The block is purely combinational: the outputs follow the inputs without a clock.

Top module: `mag_cmp_cascade`

## Requirements
- R1: Each bit pair is tested for equality with an XNOR. `eq_o` is high only when every bit of `a_word` matches the corresponding bit of `b_word`.
- R2: The slice that holds the most significant bits decides the result. When the upper four bits differ, the lower bits and the verdict inputs have no effect on the outputs.
- R3: Inside a slice, the most significant differing bit sets the verdict. Bit 3 is the slice MSB and bit 0 its LSB. If `a_word` has a 1 at that position the result is greater (`gt_o`=1), otherwise it is less (`lt_o`=1).
- R4: When the two words are fully equal, `{gt_o, lt_o, eq_o}` copies `{casc_gt_in, casc_lt_in, casc_eq_in}` unchanged, for all eight input patterns.
- R5: With the chain seed `{casc_gt_in, casc_lt_in, casc_eq_in}` = 3'b001, the outputs give the unsigned comparison of the full words: `gt_o` when a>b, `lt_o` when a<b, `eq_o` when a==b.
- R6: When exactly one verdict input is high, exactly one output is high.
- R7: When the words differ in any bit, the verdict inputs are ignored. The outputs are the same for all eight verdict input patterns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_word | input | STAGE_W*NUM_STAGES (8) | First unsigned operand |
| b_word | input | STAGE_W*NUM_STAGES (8) | Second unsigned operand |
| casc_gt_in | input | 1 | Lower-order verdict: greater |
| casc_lt_in | input | 1 | Lower-order verdict: less |
| casc_eq_in | input | 1 | Lower-order verdict: equal (tie high in a standalone use) |
| gt_o | output | 1 | a_word greater than b_word |
| lt_o | output | 1 | a_word less than b_word |
| eq_o | output | 1 | a_word equal to b_word |

## Verification
The assertions assume that every input is a known 0 or 1. They also assume that the verdict inputs are one-hot whenever a one-hot result is expected. The full-word ordering check only applies under the 3'b001 seed. The stimulus drives only resolved values. It splits the verdict input patterns into two groups: the seed and one-hot patterns, used for ordering and one-hot checks, and the zero and multi-hot patterns, used only in the pass-through and ignore checks, where the expected result is the pattern itself or the differing-word verdict.

// File: rtl/mag_cmp_pkg.sv
package mag_cmp_pkg;

    localparam int unsigned SLICE_W_DEF  = 4;
    localparam int unsigned SLICES_DEF   = 2;

    // Verdict carried between slices; packed order is gt, lt, eq (MSB first).
    typedef struct packed {
        logic gt;
        logic lt;
        logic eq;
    } verdict_t;

    localparam verdict_t SEED_EQUAL = '{gt: 1'b0, lt: 1'b0, eq: 1'b1};

    function automatic verdict_t pack_verdict(input logic g, input logic l, input logic e);
        verdict_t v;
        v.gt = g;
        v.lt = l;
        v.eq = e;
        return v;
    endfunction

    // Verdict of a slice whose own bits differ.
    function automatic verdict_t decided_verdict(input logic a_is_high);
        return pack_verdict(a_is_high, ~a_is_high, 1'b0);
    endfunction

endpackage

// File: rtl/bit_match_vec.sv
module bit_match_vec #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] a_bits,
    input  logic [W-1:0] b_bits,
    output logic [W-1:0] match
);

    for (genvar i = 0; i < W; i++) begin : g_xnor
        assign match[i] = ~(a_bits[i] ^ b_bits[i]);
    end

endmodule

// File: rtl/msb_diff_pick.sv
module msb_diff_pick #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] match,
    input  logic [W-1:0] a_bits,
    output logic         any_diff,
    output logic         a_high
);

    // Scan upward so the most significant mismatch is the last one written.
    always_comb begin
        a_high = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (!match[i]) begin
                a_high = a_bits[i];
            end
        end
    end

    assign any_diff = ~(&match);

endmodule

// File: rtl/cmp_slice.sv
module cmp_slice
    import mag_cmp_pkg::*;
#(
    parameter int unsigned W = SLICE_W_DEF
) (
    input  logic [W-1:0] a_bits,
    input  logic [W-1:0] b_bits,
    input  verdict_t     lower_in,
    output verdict_t     result
);

    logic [W-1:0] match;
    logic         any_diff;
    logic         a_high;

    bit_match_vec #(.W(W)) match_i (
        .a_bits (a_bits),
        .b_bits (b_bits),
        .match  (match)
    );

    msb_diff_pick #(.W(W)) pick_i (
        .match    (match),
        .a_bits   (a_bits),
        .any_diff (any_diff),
        .a_high   (a_high)
    );

    always_comb begin
        if (any_diff) begin
            result = decided_verdict(a_high);
        end else begin
            result = lower_in;
        end
    end

endmodule

// File: rtl/mag_cmp_cascade.sv
module mag_cmp_cascade
    import mag_cmp_pkg::*;
#(
    parameter int unsigned STAGE_W    = SLICE_W_DEF,
    parameter int unsigned NUM_STAGES = SLICES_DEF
) (
    input  logic [STAGE_W*NUM_STAGES-1:0] a_word,
    input  logic [STAGE_W*NUM_STAGES-1:0] b_word,
    input  logic                          casc_gt_in,
    input  logic                          casc_lt_in,
    input  logic                          casc_eq_in,
    output logic                          gt_o,
    output logic                          lt_o,
    output logic                          eq_o
);

    localparam int unsigned LINKS = NUM_STAGES + 1;

    verdict_t link [LINKS];

    assign link[0] = pack_verdict(casc_gt_in, casc_lt_in, casc_eq_in);

    // Slice k handles bits [k*STAGE_W +: STAGE_W]; the top slice gives the final verdict.
    for (genvar k = 0; k < NUM_STAGES; k++) begin : g_slice
        cmp_slice #(.W(STAGE_W)) slice_i (
            .a_bits   (a_word[k*STAGE_W +: STAGE_W]),
            .b_bits   (b_word[k*STAGE_W +: STAGE_W]),
            .lower_in (link[k]),
            .result   (link[k+1])
        );
    end

    assign gt_o = link[NUM_STAGES].gt;
    assign lt_o = link[NUM_STAGES].lt;
    assign eq_o = link[NUM_STAGES].eq;

endmodule

// File: rtl/mag_cmp_cascade_chk.sv
module mag_cmp_cascade_chk #(
    parameter int unsigned STAGE_W    = 4,
    parameter int unsigned NUM_STAGES = 2
) (
    input  logic [STAGE_W*NUM_STAGES-1:0] a_word,
    input  logic [STAGE_W*NUM_STAGES-1:0] b_word,
    input  logic                          casc_gt_in,
    input  logic                          casc_lt_in,
    input  logic                          casc_eq_in,
    input  logic                          gt_o,
    input  logic                          lt_o,
    input  logic                          eq_o
);

    localparam int unsigned TOP_LO = STAGE_W*(NUM_STAGES-1);

    logic known;
    assign known = !$isunknown({a_word, b_word, casc_gt_in, casc_lt_in, casc_eq_in});

    always_comb begin
        if (known) begin
            // R1: equal output demands matching words
            a_r1_eq_needs_match: assert (!eq_o || (a_word == b_word));
            // R2: top slice decides when its bits differ
            if (a_word[TOP_LO +: STAGE_W] > b_word[TOP_LO +: STAGE_W]) begin
                a_r2_top_slice_gt: assert (gt_o && !lt_o && !eq_o);
            end
            // R4: equal words pass the verdict inputs through
            if (a_word == b_word) begin
                a_r4_pass_through: assert ({gt_o, lt_o, eq_o} == {casc_gt_in, casc_lt_in, casc_eq_in});
            end
            // R5: seeded chain gives the full unsigned ordering
            if ({casc_gt_in, casc_lt_in, casc_eq_in} == 3'b001) begin
                a_r5_seed_order: assert ((gt_o == (a_word > b_word)) && (lt_o == (a_word < b_word)));
            end
            // R6: one-hot in, one-hot out
            if ($onehot({casc_gt_in, casc_lt_in, casc_eq_in})) begin
                a_r6_onehot_out: assert ($onehot({gt_o, lt_o, eq_o}));
            end
            // R7, R3: differing words give a decided verdict
            if (a_word != b_word) begin
                a_r7_ignore_lower: assert (!eq_o && (gt_o != lt_o) && (gt_o == (a_word > b_word)));
            end
        end
    end

endmodule

bind mag_cmp_cascade mag_cmp_cascade_chk #(
    .STAGE_W    (STAGE_W),
    .NUM_STAGES (NUM_STAGES)
) chk_i (.*);

// File: tb/mag_cmp_cascade_tb_top.sv
`timescale 1ns/1ps
module mag_cmp_cascade_tb_top;

    localparam int unsigned W = 8;
    localparam int unsigned NVEC = 14;

    logic clk = 1'b0;
    logic rst;
    logic [W-1:0] a_word, b_word;
    logic casc_gt_in, casc_lt_in, casc_eq_in;
    logic gt_o, lt_o, eq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mag_cmp_cascade dut_i (
        .a_word     (a_word),
        .b_word     (b_word),
        .casc_gt_in (casc_gt_in),
        .casc_lt_in (casc_lt_in),
        .casc_eq_in (casc_eq_in),
        .gt_o       (gt_o),
        .lt_o       (lt_o),
        .eq_o       (eq_o)
    );

    // Vector: {a, b, verdict in {gt,lt,eq}, expected {gt,lt,eq}}
    localparam logic [21:0] VEC [NVEC] = '{
        {8'h00, 8'h00, 3'b001, 3'b001},  // R1 equal
        {8'h5A, 8'h5A, 3'b100, 3'b100},  // R4
        {8'h5A, 8'h5A, 3'b010, 3'b010},  // R4
        {8'h80, 8'h7F, 3'b001, 3'b100},  // R2 top slice
        {8'h7F, 8'h80, 3'b001, 3'b010},  // R2
        {8'h38, 8'h3F, 3'b100, 3'b010},  // R7 lower slice decides
        {8'h39, 8'h38, 3'b010, 3'b100},  // R7
        {8'h1F, 8'h20, 3'b100, 3'b010},  // R2
        {8'hC4, 8'hC2, 3'b001, 3'b100},  // R3 bit 2 decides
        {8'h05, 8'h06, 3'b001, 3'b010},  // R3 bit 1 beats bit 0
        {8'hFF, 8'hFF, 3'b000, 3'b000},  // R4 all low
        {8'hFF, 8'hFF, 3'b111, 3'b111},  // R4 all high
        {8'hA5, 8'hA5, 3'b110, 3'b110},  // R4
        {8'hE0, 8'h0E, 3'b001, 3'b100}   // R2
    };

    task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s a=%02h b=%02h actual=%03b expected=%03b", tag, a_word, b_word, act, exp);
        end
    endtask

    task automatic apply(input logic [7:0] a, input logic [7:0] b, input logic [2:0] c);
        @(negedge clk);
        a_word = a;
        b_word = b;
        {casc_gt_in, casc_lt_in, casc_eq_in} = c;
        #1;
    endtask

    function automatic logic [2:0] ref_order(input logic [7:0] a, input logic [7:0] b);
        if (a > b) return 3'b100;
        if (a < b) return 3'b010;
        return 3'b001;
    endfunction

    initial begin
        rst = 1'b1;
        a_word = '0;
        b_word = '0;
        {casc_gt_in, casc_lt_in, casc_eq_in} = 3'b001;
        repeat (4) @(posedge clk);
        rst = 1'b0;

        // Initial state after reset, seeded chain with zero operands (R1)
        apply(8'h00, 8'h00, 3'b001);
        check("R1 initial", {gt_o, lt_o, eq_o}, 3'b001);

        for (int i = 0; i < NVEC; i++) begin
            apply(VEC[i][21:14], VEC[i][13:6], VEC[i][5:3]);
            check($sformatf("table %0d R1 R2 R3 R4 R7", i), {gt_o, lt_o, eq_o}, VEC[i][2:0]);
        end

        // R5: every operand pair with the seed
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b++) begin
                apply(a[7:0], b[7:0], 3'b001);
                check("R5 seed order", {gt_o, lt_o, eq_o}, ref_order(a[7:0], b[7:0]));
            end
        end

        // R4: equal words with every verdict input pattern
        for (int a = 0; a < 256; a++) begin
            for (int c = 0; c < 8; c++) begin
                apply(a[7:0], a[7:0], c[2:0]);
                check("R4 pass through", {gt_o, lt_o, eq_o}, c[2:0]);
            end
        end

        // R6: one-hot verdict inputs
        for (int a = 0; a < 256; a += 17) begin
            for (int b = 0; b < 256; b++) begin
                for (int c = 0; c < 3; c++) begin
                    apply(a[7:0], b[7:0], 3'b001 << c);
                    check("R6 one-hot", {2'b00, $countones({gt_o, lt_o, eq_o}) == 1}, 3'b001);
                end
            end
        end

        // R7: differing words ignore every verdict input pattern
        for (int a = 0; a < 256; a += 13) begin
            for (int b = 0; b < 256; b += 3) begin
                if (a != b) begin
                    for (int c = 0; c < 8; c++) begin
                        apply(a[7:0], b[7:0], c[2:0]);
                        check("R7 ignore lower", {gt_o, lt_o, eq_o}, ref_order(a[7:0], b[7:0]));
                    end
                end
            end
        end

        // R3 corners inside the lower slice with equal upper slice
        apply(8'h08, 8'h07, 3'b010);
        check("R3 msb of slice", {gt_o, lt_o, eq_o}, 3'b100);
        apply(8'h01, 8'h00, 3'b010);
        check("R3 lsb only", {gt_o, lt_o, eq_o}, 3'b100);

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule